// File: doc/BRIEF.md
# Segmented DAC Input Front-End

This block conditions an 8-bit parallel sample for a segmented digital-to-analog converter. An active-high invert control can flip every bit of the word. After that stage the three most significant bits are turned into seven equal-weight thermometer segments. The five least significant bits stay binary. All twelve drive lines then pass through one level-sensitive latch, which is controlled by an active-low enable.

When the enable is held low, the path from inputs to outputs is purely combinational. For low-glitch use, the enable is pulsed instead. The word is captured on the rising enable edge. The new word is presented on the falling edge, so every drive line moves at the same moment.

The block also rebuilds the ideal binary code from the latched lines. This lets the surrounding logic, or a test, confirm what the converter is being asked to produce.

Top module: `seg_dac_front`

## Requirements
- R1: When `comp` is 1, every bit of `data_in` is inverted before segment encoding and before the binary pass-through. When `comp` is 0, the word is used as given.
- R2: Segment output bit k-1 (for k = 1..7) is 1 exactly when the conditioned upper field (conditioned word bits 7:5) is at least k. As a result, the number of ones on `seg_out` equals that field.
- R3: `seg_out` is always a contiguous run of ones starting at bit 0, with no gaps.
- R4: `lsb_out[4:0]` equals bits 4:0 of the conditioned word, in the same bit positions.
- R5: While `le_n` is 0 and `rst_n` is 1, all outputs follow the inputs with no clock.
- R6: While `le_n` is 1, the outputs hold the word present at the rising edge of `le_n`. Changes on `data_in` and `comp` during that time have no effect on the outputs. A high pulse lasting one bench cycle is enough to capture a word.
- R7: When `le_n` falls after new data was set up during the high phase, all twelve drive lines and `code_out` take the new word together.
- R8: `code_out` equals 32 times the number of ones on `seg_out`, plus `lsb_out`.
- R9: Input 00h with `comp`=0 gives all drive lines at 0. Input FFh gives `seg_out`=7Fh, `lsb_out`=1Fh and `code_out`=FFh. With `comp`=1 these two results swap.
- R10: When `rst_n` is 0, all outputs go to 0 without waiting for `le_n`. If `rst_n` is released while `le_n` is 1, the outputs stay at 0 until `le_n` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of the latch |
| le_n | input | 1 | Active-low latch enable (0 = transparent) |
| comp | input | 1 | Active-high invert control for the data word |
| data_in | input | 8 | Parallel sample, bit 0 weight 1 through bit 7 weight 128 |
| seg_out | output | 7 | Latched thermometer segments, each of weight 32 |
| lsb_out | output | 5 | Latched binary low bits |
| code_out | output | 8 | Ideal code rebuilt from the latched drive lines |

## Verification
The hardest case to reach from the ports is a word that changes during the high phase of the enable and is then released on the falling edge. The outputs must first show that they ignored the change. They must then show all twelve lines moving together, and this has to be observed on both sides of the edge. The bench sets up a held word, changes both the data and the invert control while `le_n` is high, and samples at that point. It then drops `le_n` and samples again. A second hard case is reset arriving while the latch is closed. The bench asserts and releases `rst_n` with `le_n` still high, then changes the data to confirm the zero pattern persists.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  // number of set bits in the low n positions of v
  function automatic int ones_in(input logic [31:0] v, input int n);
    int c;
    c = 0;
    for (int i = 0; i < 32; i++)
      if (i < n && v[i]) c++;
    return c;
  endfunction

  // ideal code from segment count and binary low field
  function automatic int code_of(input int seg_cnt, input int low, input int low_w);
    return (seg_cnt << low_w) + low;
  endfunction
endpackage

// File: rtl/dacfe_invert.sv
module dacfe_invert #(
  parameter int W = 8
) (
  input  logic         inv,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o
);
  assign word_o = word_i ^ {W{inv}};
endmodule

// File: rtl/dacfe_thermo.sv
module dacfe_thermo #(
  parameter int IN_W = 3,
  localparam int OUT_N = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  bin_i,
  output logic [OUT_N-1:0] bar_o
);
  for (genvar k = 1; k <= OUT_N; k++) begin : g_seg
    assign bar_o[k-1] = (int'(bin_i) >= k);
  end
endmodule

// File: rtl/dacfe_latch.sv
module dacfe_latch #(
  parameter int W = 12
) (
  input  logic         rst_n,
  input  logic         en_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (!rst_n)     q <= '0;
    else if (!en_n) q <= d;
  end
endmodule

// File: rtl/dacfe_rebuild.sv
module dacfe_rebuild #(
  parameter int SEG_N  = 7,
  parameter int LOW_W  = 5,
  parameter int CODE_W = 8
) (
  input  logic [SEG_N-1:0]  seg_i,
  input  logic [LOW_W-1:0]  low_i,
  output logic [CODE_W-1:0] code_o
);
  import dacfe_pkg::*;
  logic [31:0] seg_ext;
  int          code_full;
  assign seg_ext   = 32'(seg_i);
  assign code_full = code_of(ones_in(seg_ext, SEG_N), int'(low_i), LOW_W);
  assign code_o    = code_full[CODE_W-1:0];
endmodule

// File: rtl/seg_dac_front.sv
module seg_dac_front #(
  parameter int DATA_W = 8,
  parameter int MSB_W  = 3,
  localparam int SEG_N = (1 << MSB_W) - 1,
  localparam int LSB_W = DATA_W - MSB_W
) (
  input  logic              rst_n,
  input  logic              le_n,
  input  logic              comp,
  input  logic [DATA_W-1:0] data_in,
  output logic [SEG_N-1:0]  seg_out,
  output logic [LSB_W-1:0]  lsb_out,
  output logic [DATA_W-1:0] code_out
);
  localparam int DRV_W = SEG_N + LSB_W;

  // named internal events
  logic [DATA_W-1:0] cond_word;
  logic [MSB_W-1:0]  upper_bits;
  logic [SEG_N-1:0]  therm_next;
  logic [DRV_W-1:0]  drive_next;
  logic [DRV_W-1:0]  drive_q;

  dacfe_invert #(.W(DATA_W)) u_inv (
    .inv(comp), .word_i(data_in), .word_o(cond_word)
  );

  assign upper_bits = cond_word[DATA_W-1:LSB_W];

  dacfe_thermo #(.IN_W(MSB_W)) u_therm (
    .bin_i(upper_bits), .bar_o(therm_next)
  );

  assign drive_next = {therm_next, cond_word[LSB_W-1:0]};

  dacfe_latch #(.W(DRV_W)) u_lat (
    .rst_n(rst_n), .en_n(le_n), .d(drive_next), .q(drive_q)
  );

  assign seg_out = drive_q[DRV_W-1:LSB_W];
  assign lsb_out = drive_q[LSB_W-1:0];

  dacfe_rebuild #(.SEG_N(SEG_N), .LOW_W(LSB_W), .CODE_W(DATA_W)) u_rb (
    .seg_i(seg_out), .low_i(lsb_out), .code_o(code_out)
  );
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
  parameter int DATA_W = 8,
  parameter int MSB_W  = 3,
  localparam int SEG_N = (1 << MSB_W) - 1,
  localparam int LSB_W = DATA_W - MSB_W
) (
  input logic              rst_n,
  input logic              le_n,
  input logic              comp,
  input logic [DATA_W-1:0] data_in,
  input logic [SEG_N-1:0]  seg_out,
  input logic [LSB_W-1:0]  lsb_out,
  input logic [DATA_W-1:0] code_out
);
  logic [DATA_W-1:0] held;
  logic              held_vld;
  logic [DATA_W-1:0] want;
  assign want = data_in ^ {DATA_W{comp}};

  always_ff @(posedge le_n or negedge rst_n) begin
    if (!rst_n) begin
      held     <= '0;
      held_vld <= 1'b0;
    end else begin
      held     <= code_out;
      held_vld <= 1'b1;
    end
  end

  AST_COMP_INVERT: assert property (@(posedge le_n) disable iff (!rst_n)
    comp |-> code_out == ~data_in); // R1
  AST_SEG_COUNT: assert property (@(posedge le_n) disable iff (!rst_n)
    $countones(seg_out) == int'(want[DATA_W-1:LSB_W])); // R2
  AST_SEG_CONTIG: assert property (@(posedge le_n) disable iff (!rst_n)
    (seg_out & (seg_out + SEG_N'(1))) == '0); // R3
  AST_LSB_PASS: assert property (@(posedge le_n) disable iff (!rst_n)
    lsb_out == want[LSB_W-1:0]); // R4
  AST_TRANSPARENT: assert property (@(posedge le_n) disable iff (!rst_n)
    !comp |-> code_out == data_in); // R5
  AST_HOLD_HIGH: assert property (@(negedge le_n) disable iff (!rst_n)
    held_vld |-> code_out == held); // R6
  AST_ZERO_SCALE: assert property (@(posedge le_n) disable iff (!rst_n)
    (data_in == '0 && !comp) |-> (seg_out == '0 && lsb_out == '0)); // R9
endmodule

bind seg_dac_front dacfe_chk #(.DATA_W(DATA_W), .MSB_W(MSB_W)) u_chk (.*);

// File: tb/sim_seg_dac_front.sv
module sim_seg_dac_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       le_n = 1'b1;
  logic       comp = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic [6:0] seg_out;
  logic [4:0] lsb_out;
  logic [7:0] code_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  seg_dac_front u0 (
    .rst_n(rst_n), .le_n(le_n), .comp(comp), .data_in(data_in),
    .seg_out(seg_out), .lsb_out(lsb_out), .code_out(code_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bar_of(input int up);
    int b = 0;
    for (int k = 0; k < 7; k++) if (k < up) b = b | (1 << k);
    return b;
  endfunction

  task automatic step();
    @(posedge clk);
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  // outputs compared to the word w as seen after conditioning
  task automatic expect_word(input string tag, input int w);
    int up = (w >> 5) & 7;
    chk({tag, " seg R2"}, int'(seg_out), bar_of(up));
    chk({tag, " lsb R4"}, int'(lsb_out), w & 31);
    chk({tag, " code R8"}, int'(code_out), 32 * up + (w & 31));
    chk({tag, " contig R3"}, int'((seg_out & (seg_out + 7'd1)) == 7'd0), 1);
  endtask

  task automatic t_reset();
    step(); data_in = 8'hA7;
    sample();
    chk("reset seg R10", int'(seg_out), 0);
    chk("reset lsb R10", int'(lsb_out), 0);
    chk("reset code R10", int'(code_out), 0);
    step(); rst_n = 1'b1;
    step(); data_in = 8'h3C;
    sample();
    chk("reset held R10", int'(code_out), 0);
  endtask

  task automatic t_sweep();
    step(); le_n = 1'b0;
    for (int c = 0; c < 2; c++) begin
      for (int v = 0; v < 256; v++) begin
        step(); comp = c[0]; data_in = 8'(v);
        sample();
        expect_word(c ? "sweep inv R1" : "sweep R5", c ? (~v & 255) : v);
      end
    end
  endtask

  task automatic t_hold();
    step(); comp = 1'b0; le_n = 1'b0; data_in = 8'h9B;
    step(); le_n = 1'b1;
    step(); data_in = 8'h24; comp = 1'b1;
    sample();
    expect_word("hold R6", 8'h9B);
    step(); data_in = 8'hFF;
    sample();
    expect_word("hold2 R6", 8'h9B);
  endtask

  task automatic t_falling();
    step(); comp = 1'b0; data_in = 8'h5E;
    sample();
    expect_word("pre-fall R6", 8'h9B);
    step(); le_n = 1'b0;
    sample();
    expect_word("fall R7", 8'h5E);
    // one-cycle high pulse captures a word
    step(); data_in = 8'hC3;
    step(); le_n = 1'b1;
    step(); le_n = 1'b0; data_in = 8'hC3;
    step(); le_n = 1'b1;
    step(); data_in = 8'h11;
    sample();
    expect_word("pulse R6", 8'hC3);
  endtask

  task automatic t_scale();
    step(); le_n = 1'b0; comp = 1'b0; data_in = 8'h00;
    sample();
    chk("zero seg R9", int'(seg_out), 0);
    chk("zero lsb R9", int'(lsb_out), 0);
    step(); data_in = 8'hFF;
    sample();
    chk("full seg R9", int'(seg_out), 8'h7F);
    chk("full lsb R9", int'(lsb_out), 8'h1F);
    chk("full code R9", int'(code_out), 8'hFF);
    step(); comp = 1'b1;
    sample();
    chk("full inv R9", int'(code_out), 0);
    step(); data_in = 8'h00;
    sample();
    chk("zero inv R9", int'(seg_out), 8'h7F);
  endtask

  task automatic t_reset_hold();
    step(); comp = 1'b0; data_in = 8'hE6;
    step(); le_n = 1'b1;
    sample();
    expect_word("pre-rst R6", 8'hE6);
    step(); rst_n = 1'b0;
    sample();
    chk("rst closed R10", int'(code_out), 0);
    step(); rst_n = 1'b1;
    step(); data_in = 8'h77;
    sample();
    chk("rst released R10", int'(code_out), 0);
    step(); le_n = 1'b0;
    sample();
    expect_word("after rst R5", 8'h77);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_hold();
    t_falling();
    t_scale();
    t_reset_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule